// File: doc/BRIEF.md
# External Memory Bus Controller

This block turns single read and write requests from the core side into cycles on an external memory bus. A request carries a 24-bit byte address, 16 bits of write data and two byte enables. The controller drives a 16-bit port that holds either address followed by data (multiplexed) or data only (demultiplexed). A separate 16-bit low address output and an 8-bit segment output carry the address. An address latch strobe, an active-low read strobe and an active-low write strobe complete the bus.

Four static inputs set the mode: multiplexed or demultiplexed, 8-bit or 16-bit data path, whole-word or low-byte write strobe behaviour, and whether the ready input may stretch an access. The requester raises `reqValid` while `busy` is low and waits for the one-cycle `done` pulse. For reads, `done` comes with the assembled data. On an 8-bit path a word access becomes two byte cycles.

Top module: `extBusTop`

## Requirements
- R1: After reset `rdN` and `wrN` are high, `ale`, `busy` and `done` are low, and `portOe` is all zero.
- R2: A request is taken only when the controller is idle. `busy` is high from the cycle after acceptance until `done`. `done` is a single-cycle pulse in the cycle after the last byte cycle's recovery. The total latency is 3 cycles per byte cycle, plus the wait cycles, plus 1. A request raised during an access is ignored.
- R3: Each byte cycle runs ADDRESS, STROBE, optional WAIT, then RECOVER. In multiplexed modes `ale` is high only in the ADDRESS cycle, with the address on `portOut` and all 16 enables on. In demultiplexed modes `ale` never rises.
- R4: During an access `segAddr` carries address bits 23..16, with bit 0 the least significant segment line. `lowAddr` carries bits 15..0 of the current byte cycle's address.
- R5: `rdN` is low in the STROBE and WAIT cycles of every read byte cycle. During those cycles the data lanes are not driven: in multiplexed 16-bit mode `portOe` is 0x0000, and in multiplexed 8-bit mode it is 0xFF00.
- R6: In demultiplexed 16-bit mode data uses all 16 port bits. In demultiplexed 8-bit mode data uses bits 7..0, and bits 15..8 are never driven (`portOe[15:8]` is always 0).
- R7: In multiplexed 8-bit mode `portOut[15:8]` holds address bits 15..8 with its enables on for the whole access. Bits 7..0 carry the address first and then the data.
- R8: With `cfgWrLowByte`=0, `wrN` is low in the STROBE and WAIT cycles of every write byte cycle. During a write the data lanes stay enabled from ADDRESS through RECOVER. `rdN` and `wrN` are never low together.
- R9: With `cfgWrLowByte`=1 on a 16-bit path, `wrN` goes low only when `reqBe[0]`=1 (bit 0 enables the low byte). On an 8-bit path it goes low for every write byte cycle.
- R10: With `cfgRdyEn`=1, each cycle in which `ready` is sampled high during STROBE or WAIT adds one more strobe cycle. With `cfgRdyEn`=0, `ready` is ignored and the strobe lasts one cycle.
- R11: On an 8-bit path, reads make two byte cycles: the low byte at the request address, then the high byte at that address plus one, with the carry reaching `segAddr`. Writes make one byte cycle per set enable in the same order. A byte-1-only write runs a single cycle at address plus one.
- R12: Read data is taken from `portIn` at the end of RECOVER. On a 16-bit path `rdData` is the full port word. On an 8-bit path `rdData[7:0]` comes from the first byte cycle and `rdData[15:8]` from the second, using port bits 7..0 each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMux | input | 1 | 1 = multiplexed address/data |
| cfgWide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| cfgWrLowByte | input | 1 | 1 = write strobe only for low-byte writes on a 16-bit path |
| cfgRdyEn | input | 1 | 1 = ready input may insert wait cycles |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Byte address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables (bit 0 = low byte) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read data, valid with done |
| portIn | input | 16 | Port input lines |
| portOut | output | 16 | Port output lines |
| portOe | output | 16 | Per-bit port output enables |
| segAddr | output | 8 | Segment address lines 23..16 |
| lowAddr | output | 16 | Address lines 15..0 |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ready | input | 1 | High = insert wait cycles |

## Verification
The hardest cases to reach are requests raised in the middle of an access and write cycles that run with no strobe at all. In the low-byte write mode a high-byte-only write on a 16-bit path passes through every state and never asserts `wrN`. The bench catches a wrong strobe in that case because every expected strobe sits in a queue, and the queue must be empty when `done` arrives. A second request is raised during the STROBE and RECOVER cycles of a running access. The monitor then treats any unqueued strobe as a failure. A split read at an address ending in 0xFFFF drives the carry into the segment lines.

// File: rtl/extBusPkg.sv
package extBusPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_WAIT,
    ST_RECOVER
  } busState_t;

  typedef struct packed {
    logic load;       // take a new request
    logic advance;    // step to the second byte cycle
    logic capture;    // sample read data
    logic addrPhase;  // address cycle
    logic strobeOn;   // strobe cycles (STROBE/WAIT)
    logic active;     // any non-idle cycle
  } pathCtl_t;
endpackage

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     cfgRdyEn,
  input  logic     ready,
  input  logic     lastByte,
  output pathCtl_t ctl,
  output logic     busy,
  output logic     done
);
  busState_t state, stateNext;
  logic stretch;

  assign stretch = cfgRdyEn && ready;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_ADDR;
      ST_ADDR:    stateNext = ST_STROBE;
      ST_STROBE:  stateNext = stretch ? ST_WAIT : ST_RECOVER;
      ST_WAIT:    stateNext = stretch ? ST_WAIT : ST_RECOVER;
      ST_RECOVER: stateNext = lastByte ? ST_IDLE : ST_ADDR;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_RECOVER) && lastByte;
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && reqValid;
    ctl.advance   = (state == ST_RECOVER) && !lastByte;
    ctl.capture   = (state == ST_RECOVER);
    ctl.addrPhase = (state == ST_ADDR);
    ctl.strobeOn  = (state == ST_STROBE) || (state == ST_WAIT);
    ctl.active    = (state != ST_IDLE);
  end

  assign busy = (state != ST_IDLE);

  // R2: done lasts one cycle and follows a busy cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  // R10: wait state holds while ready is enabled and high
  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && cfgRdyEn && ready) |=> (state == ST_WAIT));
  p_no_wait_when_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && !cfgRdyEn) |=> (state == ST_RECOVER));
endmodule

// File: rtl/extBusPath.sv
module extBusPath
  import extBusPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMux,
  input  logic              cfgWide,
  input  logic              cfgWrLowByte,
  input  pathCtl_t          ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  input  logic [DATA_W-1:0] portIn,
  output logic              lastByte,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] portOut,
  output logic [DATA_W-1:0] portOe,
  output logic [ADDR_W-DATA_W-1:0] segAddr,
  output logic [DATA_W-1:0] lowAddr,
  output logic              ale,
  output logic              rdN,
  output logic              wrN
);
  localparam int LANE_W = DATA_W / 2;
  localparam int SEG_W  = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ, curAddr;
  logic [DATA_W-1:0] wdataQ, rdQ, wrWord;
  logic [1:0]        beQ, beEff;
  logic              writeQ, byteSel, needHigh, wrAllowed, narrowStep;
  logic [LANE_W-1:0] loOut, hiOut;
  logic              loOe, hiOe;

  assign beEff = (reqBe == 2'b00) ? 2'b11 : reqBe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      beQ     <= 2'b11;
      writeQ  <= 1'b0;
      byteSel <= 1'b0;
      rdQ     <= '0;
    end else begin
      if (ctl.load) begin
        addrQ   <= reqAddr;
        wdataQ  <= reqWdata;
        beQ     <= beEff;
        writeQ  <= reqWrite;
        byteSel <= !cfgWide && reqWrite && !beEff[0];
        rdQ     <= '0;
      end else if (ctl.advance) begin
        byteSel <= 1'b1;
      end
      if (ctl.capture && !writeQ) begin
        if (cfgWide)      rdQ <= portIn;
        else if (byteSel) rdQ[DATA_W-1:LANE_W] <= portIn[LANE_W-1:0];
        else              rdQ[LANE_W-1:0] <= portIn[LANE_W-1:0];
      end
    end
  end

  assign needHigh   = !writeQ || beQ[1];
  assign lastByte   = cfgWide || byteSel || !needHigh;
  assign narrowStep = !cfgWide && byteSel;
  assign curAddr    = addrQ + {{(ADDR_W-1){1'b0}}, narrowStep};
  assign rdData     = rdQ;

  assign segAddr = ctl.active ? curAddr[ADDR_W-1:DATA_W] : '0;
  assign lowAddr = ctl.active ? curAddr[DATA_W-1:0] : '0;

  // strobes
  assign wrAllowed = !cfgWrLowByte || !cfgWide || beQ[0];
  assign ale = ctl.addrPhase && cfgMux;
  assign rdN = !(ctl.strobeOn && !writeQ);
  assign wrN = !(ctl.strobeOn && writeQ && wrAllowed);

  // write data placed on the lanes
  assign wrWord = cfgWide ? wdataQ :
                  {{LANE_W{1'b0}}, (byteSel ? wdataQ[DATA_W-1:LANE_W] : wdataQ[LANE_W-1:0])};

  // low lane: address in mux address phase, else data
  always_comb begin
    if (cfgMux && ctl.addrPhase) begin
      loOut = curAddr[LANE_W-1:0];
      loOe  = 1'b1;
    end else begin
      loOut = wrWord[LANE_W-1:0];
      loOe  = ctl.active && writeQ;
    end
  end

  // high lane: data when wide, address when mux narrow, unused when demux narrow
  always_comb begin
    if (cfgWide) begin
      if (cfgMux && ctl.addrPhase) begin
        hiOut = curAddr[DATA_W-1:LANE_W];
        hiOe  = 1'b1;
      end else begin
        hiOut = wrWord[DATA_W-1:LANE_W];
        hiOe  = ctl.active && writeQ;
      end
    end else if (cfgMux) begin
      hiOut = curAddr[DATA_W-1:LANE_W];
      hiOe  = ctl.active;
    end else begin
      hiOut = '0;
      hiOe  = 1'b0;
    end
  end

  assign portOut = {hiOut, loOut};
  assign portOe  = {{LANE_W{hiOe}}, {LANE_W{loOe}}};

  // R8: strobes never overlap
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  // R3: address latch only in multiplexed modes, never with a strobe
  p_ale_mux_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (cfgMux && rdN && wrN));
  // R5: no drive on the multiplexed low lane while reading
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && cfgMux) |-> (portOe[LANE_W-1:0] == '0));
  // R6: high lane left alone in demultiplexed 8-bit mode
  p_narrow_high_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMux && !cfgWide) |-> (portOe[DATA_W-1:LANE_W] == '0));
  // R4: address stable through a strobe
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && $past(!rdN)) |-> ($stable(lowAddr) && $stable(segAddr)));
  initial assert (SEG_W > 0);
endmodule

// File: rtl/extBusTop.sv
module extBusTop
  import extBusPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMux,
  input  logic              cfgWide,
  input  logic              cfgWrLowByte,
  input  logic              cfgRdyEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] portIn,
  output logic [DATA_W-1:0] portOut,
  output logic [DATA_W-1:0] portOe,
  output logic [ADDR_W-DATA_W-1:0] segAddr,
  output logic [DATA_W-1:0] lowAddr,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  input  logic              ready
);
  pathCtl_t ctl;
  logic     lastByte;

  extBusCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgRdyEn(cfgRdyEn),
    .ready(ready), .lastByte(lastByte), .ctl(ctl), .busy(busy), .done(done)
  );

  extBusPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .cfgMux(cfgMux), .cfgWide(cfgWide),
    .cfgWrLowByte(cfgWrLowByte), .ctl(ctl), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .portIn(portIn),
    .lastByte(lastByte), .rdData(rdData), .portOut(portOut), .portOe(portOe),
    .segAddr(segAddr), .lowAddr(lowAddr), .ale(ale), .rdN(rdN), .wrN(wrN)
  );
endmodule

// File: tb/tb_extBusTop.sv
module tb_extBusTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMux = 0, cfgWide = 1, cfgWrLowByte = 0, cfgRdyEn = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = 2'b11;
  logic busy, done, ale, rdN, wrN;
  logic ready = 0;
  logic [15:0] rdData, portIn, portOut, portOe, lowAddr;
  logic [7:0]  segAddr;

  always #10 clk = ~clk;

  extBusTop dut (
    .clk(clk), .rstN(rstN), .cfgMux(cfgMux), .cfgWide(cfgWide),
    .cfgWrLowByte(cfgWrLowByte), .cfgRdyEn(cfgRdyEn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .busy(busy), .done(done), .rdData(rdData), .portIn(portIn),
    .portOut(portOut), .portOe(portOe), .segAddr(segAddr), .lowAddr(lowAddr),
    .ale(ale), .rdN(rdN), .wrN(wrN), .ready(ready)
  );

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h5A3C;
  endfunction
  assign portIn = pat({segAddr, lowAddr});

  typedef struct {
    bit          wr;
    logic [23:0] a;
    logic [15:0] d;
    int          len;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  int waitCfg = 0;
  bit forceReady = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: pops expected strobe cycles and drives ready
  bit prevStrobe = 0, aleSeen = 0;
  logic [15:0] aleAddr = '0;
  int len = 0, expLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      automatic bit strobeNow = !rdN || !wrN;
      if (ale) begin
        aleSeen = 1;
        aleAddr = portOut;
        chk(portOe == 16'hFFFF, "R3 ale cycle enables", portOe, 16'hFFFF);
      end
      if (strobeNow && !prevStrobe) begin
        len = 1;
        if (q.size() == 0) begin
          chk(0, "R2 unexpected strobe", {segAddr, lowAddr}, 0);
          expLen = 1;
        end else begin
          automatic item_t it = q.pop_front();
          automatic logic [15:0] eo;
          expLen = it.len;
          chk(!wrN == it.wr, "R5/R8 strobe kind", !wrN, it.wr);
          chk({segAddr, lowAddr} == it.a, "R4 address", {segAddr, lowAddr}, it.a);
          if (cfgMux) chk(aleSeen && aleAddr == it.a[15:0], "R3 latched address", aleAddr, it.a[15:0]);
          else        chk(!aleSeen, "R3 no ale in demux", aleSeen, 0);
          if (it.wr) eo = (!cfgMux && !cfgWide) ? 16'h00FF : 16'hFFFF;
          else       eo = (cfgMux && !cfgWide) ? 16'hFF00 : 16'h0000;
          chk(portOe == eo, "R5/R6 port enables", portOe, eo);
          if (it.wr) begin
            if (cfgWide) chk(portOut == it.d, "R6/R8 write word", portOut, it.d);
            else         chk(portOut[7:0] == it.d[7:0], "R11 write byte", portOut[7:0], it.d[7:0]);
          end
          if (cfgMux && !cfgWide)
            chk(portOut[15:8] == it.a[15:8], "R7 high lane address", portOut[15:8], it.a[15:8]);
        end
        aleSeen = 0;
      end else if (strobeNow) begin
        len++;
      end
      if (!strobeNow && prevStrobe)
        chk(len == expLen, "R10 strobe length", len, expLen);
      ready = forceReady ? 1'b1 : (strobeNow && len <= waitCfg);
      prevStrobe = strobeNow;
    end
  end

  task automatic access(input bit wr, input logic [23:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int w, input bit poke);
    automatic logic [1:0] bef = (be == 2'b00) ? 2'b11 : be;
    automatic int nCyc = 0, extra = 0, c;
    automatic int sl = (cfgRdyEn && !forceReady) ? w + 1 : 1;
    automatic logic [15:0] expRd;
    waitCfg = w;
    if (cfgWide) begin
      nCyc = 1;
      if (!wr || !cfgWrLowByte || bef[0]) begin
        q.push_back('{wr, a, d, sl});
        extra += sl - 1;
      end
      expRd = pat(a);
    end else begin
      if (!wr || bef[0]) begin
        q.push_back('{wr, a, {8'h00, d[7:0]}, sl});
        nCyc++; extra += sl - 1;
      end
      if (!wr || bef[1]) begin
        q.push_back('{wr, a + 24'd1, {8'h00, d[15:8]}, sl});
        nCyc++; extra += sl - 1;
      end
      expRd = {pat(a + 24'd1)[7:0], pat(a)[7:0]};
    end
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    @(negedge clk);
    reqValid = 0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    c = 1;
    while (!done && c < 400) begin
      @(negedge clk);
      c++;
      if (poke && c == 2) begin
        reqValid = 1; reqWrite = 1; reqAddr = 24'hABCDE0; reqBe = 2'b11;
      end
      if (c == 3) reqValid = 0;
      if (c > 1 && !done) chk(busy == 1'b1, "R2 busy held", busy, 1);
    end
    chk(c == 3 * nCyc + extra + 1, "R2 latency to done", c, 3 * nCyc + extra + 1);
    chk(busy == 1'b0, "R2 busy clear at done", busy, 0);
    if (!wr) chk(rdData == expRd, "R12 read data", rdData, expRd);
    chk(q.size() == 0, "R9/R11 all strobes seen", q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single pulse", done, 0);
    if (poke) begin
      @(negedge clk);
      chk(busy == 1'b0 && rdN && wrN, "R2 request ignored while busy", busy, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdN && wrN && !ale, "R1 strobes idle", {rdN, wrN, ale}, 3'b110);
    chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    chk(portOe == 16'h0, "R1 port released", portOe, 0);
    rstN = 1;
    @(negedge clk);

    // demultiplexed 16-bit
    cfgMux = 0; cfgWide = 1; cfgWrLowByte = 0; cfgRdyEn = 0;
    access(0, 24'h3A1234, 16'h0, 2'b11, 0, 0);
    access(1, 24'h051000, 16'hBEEF, 2'b11, 0, 0);
    // multiplexed 16-bit with waits
    cfgMux = 1; cfgRdyEn = 1;
    access(0, 24'h7F00AA, 16'h0, 2'b11, 2, 0);
    access(1, 24'h000100, 16'h1357, 2'b11, 3, 0);
    // low-byte write mode on 16-bit bus (R9)
    cfgWrLowByte = 1;
    access(1, 24'h000200, 16'hAA55, 2'b10, 0, 0);
    access(1, 24'h000204, 16'h66CC, 2'b01, 1, 0);
    // multiplexed 8-bit: split read with segment carry (R11)
    cfgWide = 0;
    access(0, 24'h12FFFF, 16'h0, 2'b11, 0, 0);
    access(1, 24'h400010, 16'hC0DE, 2'b11, 1, 0);
    access(1, 24'h400020, 16'h9A00, 2'b10, 0, 0);
    // demultiplexed 8-bit
    cfgMux = 0; cfgWrLowByte = 0;
    access(0, 24'h0A0A00, 16'h0, 2'b11, 1, 0);
    access(1, 24'h0B0002, 16'h4321, 2'b11, 0, 0);
    // ready ignored when disabled (R10)
    cfgWide = 1; cfgRdyEn = 0; forceReady = 1;
    access(0, 24'h222222, 16'h0, 2'b11, 5, 0);
    forceReady = 0;
    @(negedge clk);
    // request raised during an access (R2)
    cfgRdyEn = 1;
    access(0, 24'h333330, 16'h0, 2'b11, 0, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule